// File: doc/BRIEF.md
# Timer Tick Enable Generator

This block produces the tick strobes that drive a pair of timers. Everything runs on one fast system clock. Each possible time base arrives as a one-cycle enable pulse: a 24 MHz oscillator tick, a tick from an external pin and a 32 kHz low-power tick. A single configuration byte, written and read over a small register port, selects a source and a divide ratio for two outputs. These are a capture tick, which divides by even ratios or can be switched off, and an interval tick, which divides by 1 to 4 and can also be fed by the capture tick.

A third strobe marks every `LONG_DIV` capture ticks. With the default 4096 and a 4 MHz capture tick, this gives a pulse every 1024 µs. The period of this strobe follows whatever rate the capture tick actually runs at. When a field of the configuration byte changes value, the divider that the field controls restarts. The first tick after the change therefore comes a full new period later.

Top module: `tmr_tick_gen`

## Requirements
- R1: After reset the configuration byte reads 0xA7 ^ 0x28 = 0x8F, and the capture, interval and long strobes are all low.
- R2: A write with `bus_addr == CFG_ADDR` stores `bus_wdata`. A read at `CFG_ADDR` returns the stored byte unchanged, and a read at any other address returns 0.
- R3: Bits 5:4 choose the capture source: 00 oscillator tick, 01 external tick, 10 low-power tick. Code 11 stops the capture tick.
- R4: Bits 7:6 set the capture ratio. Codes 00, 01, 10 and 11 give ratios 2, 4, 6 and 8. The capture tick is a one-cycle pulse in the cycle after every N-th selected source pulse.
- R5: Bits 1:0 choose the interval source. Codes 00, 01 and 10 select the same sources as the capture field. Code 11 selects the capture tick output.
- R6: Bits 3:2 set the interval ratio. Codes 00, 01, 10 and 11 give ratios 1, 2, 3 and 4. With ratio 1, every selected source pulse appears one cycle later on the interval tick.
- R7: A write that changes bits 7:4 clears the capture count. A write that changes bits 3:0 clears the interval count. A source pulse in the same cycle as such a write is discarded. A write that leaves a field at the same value does not disturb that field's count.
- R8: The long strobe is a one-cycle pulse in the cycle after every `LONG_DIV`-th capture tick.
- R9: While capture code 11 is selected, a cascaded interval tick and the long strobe stay low, and their counts hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_osc | input | 1 | Oscillator enable pulse |
| tick_ext | input | 1 | External pin enable pulse |
| tick_lp | input | 1 | Low-power oscillator enable pulse |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| cap_tick | output | 1 | Divided capture tick |
| itv_tick | output | 1 | Divided interval tick |
| long_tick | output | 1 | Strobe every LONG_DIV capture ticks |

## Verification
A configuration write that changes a field can arrive in the same cycle as a selected source pulse. The write takes precedence: the pulse is dropped and the count restarts from zero. The bench provokes this overlap by issuing random reconfiguring writes during dense random tick traffic. Some of these writes repeat the current value, so the case where the count must be kept is also covered. A cycle-exact model in the bench tracks when each later tick is due. Every cycle, the bench compares all three strobes against that model, so a single lost or extra pulse after such a collision is caught.

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int ADDR_W = 4,
  parameter int CFG_ADDR = 1,
  parameter logic [7:0] RST_CFG = 8'h8F,
  parameter int LONG_DIV = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_osc,
  input  logic              tick_ext,
  input  logic              tick_lp,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              cap_tick,
  output logic              itv_tick,
  output logic              long_tick
);
  localparam int LW = (LONG_DIV > 2) ? $clog2(LONG_DIV) : 1;
  localparam logic [ADDR_W-1:0] HIT = ADDR_W'(CFG_ADDR);

  logic [7:0]    cfg_q;
  logic [2:0]    cap_cnt;
  logic [1:0]    itv_cnt;
  logic [LW-1:0] long_cnt;

  function automatic logic pick(input logic [1:0] code, input logic o, input logic e,
                                input logic l, input logic alt);
    case (code)
      2'b00:   pick = o;
      2'b01:   pick = e;
      2'b10:   pick = l;
      default: pick = alt;
    endcase
  endfunction

  wire wr_hit  = bus_wr && (bus_addr == HIT);
  wire cap_chg = wr_hit && (bus_wdata[7:4] != cfg_q[7:4]);
  wire itv_chg = wr_hit && (bus_wdata[3:0] != cfg_q[3:0]);

  wire       cap_src  = pick(cfg_q[5:4], tick_osc, tick_ext, tick_lp, 1'b0);
  wire       itv_src  = pick(cfg_q[1:0], tick_osc, tick_ext, tick_lp, cap_tick);
  wire [2:0] cap_last = {cfg_q[7:6], 1'b1};
  wire [1:0] itv_last = cfg_q[3:2];

  assign bus_rdata = (bus_addr == HIT) ? cfg_q : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= RST_CFG;
    else if (wr_hit) cfg_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cap_chg) begin
      cap_cnt  <= '0;
      cap_tick <= 1'b0;
    end else begin
      cap_tick <= cap_src && (cap_cnt == cap_last);
      if (cap_src) cap_cnt <= (cap_cnt == cap_last) ? 3'd0 : cap_cnt + 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || itv_chg) begin
      itv_cnt  <= '0;
      itv_tick <= 1'b0;
    end else begin
      itv_tick <= itv_src && (itv_cnt == itv_last);
      if (itv_src) itv_cnt <= (itv_cnt == itv_last) ? 2'd0 : itv_cnt + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      long_cnt  <= '0;
      long_tick <= 1'b0;
    end else begin
      long_tick <= cap_tick && (long_cnt == LW'(LONG_DIV - 1));
      if (cap_tick) long_cnt <= (long_cnt == LW'(LONG_DIV - 1)) ? '0 : long_cnt + 1'b1;
    end
  end
endmodule

module tmr_tick_gen_chk #(
  parameter int ADDR_W = 4,
  parameter int CFG_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        cfg,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic              cap_tick,
  input logic              itv_tick,
  input logic              long_tick
);
  AST_CAP_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[5:4] == 2'b11) |=> !cap_tick); // R3
  AST_CAP_NO_BACK2BACK: assert property (@(posedge clk) disable iff (!rst_n)
    cap_tick |=> !cap_tick); // R4
  AST_CASCADE_FOLLOWS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (itv_tick && $past(cfg[1:0]) == 2'b11) |-> $past(cap_tick)); // R5
  AST_LONG_AFTER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    long_tick |-> $past(cap_tick)); // R8
  AST_LONG_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg[5:4]) == 2'b11 && cfg[5:4] == 2'b11) |=> !long_tick); // R9
  AST_RDATA_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != ADDR_W'(CFG_ADDR)) |-> (bus_rdata == 8'h00)); // R2
endmodule

bind tmr_tick_gen tmr_tick_gen_chk #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .cap_tick(cap_tick), .itv_tick(itv_tick), .long_tick(long_tick));

// File: tb/tb_tmr_tick_gen.sv
`timescale 1ns/1ps
module tb_tmr_tick_gen;
  localparam int AW = 4;
  localparam int CA = 1;
  localparam int LD = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_osc = 0, tick_ext = 0, tick_lp = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = AW'(CA);
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic cap_tick, itv_tick, long_tick;

  int total = 0, bad = 0;
  string tag = "R1";
  bit live = 0;
  int n_cap = 0, n_itv = 0, n_long = 0;

  always #2 clk = ~clk;

  tmr_tick_gen #(.ADDR_W(AW), .CFG_ADDR(CA), .LONG_DIV(LD)) dut (
    .clk(clk), .rst_n(rst_n), .tick_osc(tick_osc), .tick_ext(tick_ext), .tick_lp(tick_lp),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_tick(cap_tick), .itv_tick(itv_tick), .long_tick(long_tick));

  function automatic bit src_of(input logic [1:0] c, input bit o, input bit e, input bit l, input bit a);
    return (c == 2'd0) ? o : (c == 2'd1) ? e : (c == 2'd2) ? l : a;
  endfunction
  function automatic int cap_ratio(input logic [7:0] c); return 2 * (int'(c[7:6]) + 1); endfunction
  function automatic int itv_ratio(input logic [7:0] c); return int'(c[3:2]) + 1; endfunction

  logic [7:0] m_cfg;
  int m_cc, m_ic, m_lc;
  bit m_cap, m_itv, m_long;
  always @(posedge clk) begin
    bit wr, cs, is;
    if (!rst_n) begin
      m_cfg <= 8'h8F; m_cc <= 0; m_ic <= 0; m_lc <= 0;
      m_cap <= 0; m_itv <= 0; m_long <= 0;
    end else begin
      wr = bus_wr && (bus_addr == AW'(CA));
      cs = src_of(m_cfg[5:4], tick_osc, tick_ext, tick_lp, 1'b0);
      is = src_of(m_cfg[1:0], tick_osc, tick_ext, tick_lp, m_cap);
      m_cap <= 0; m_itv <= 0; m_long <= 0;
      if (wr && bus_wdata[7:4] != m_cfg[7:4]) m_cc <= 0;
      else if (cs) begin
        if (m_cc + 1 == cap_ratio(m_cfg)) begin m_cc <= 0; m_cap <= 1; end
        else m_cc <= m_cc + 1;
      end
      if (wr && bus_wdata[3:0] != m_cfg[3:0]) m_ic <= 0;
      else if (is) begin
        if (m_ic + 1 == itv_ratio(m_cfg)) begin m_ic <= 0; m_itv <= 1; end
        else m_ic <= m_ic + 1;
      end
      if (m_cap) begin
        if (m_lc + 1 == LD) begin m_lc <= 0; m_long <= 1; end
        else m_lc <= m_lc + 1;
      end
      if (wr) m_cfg <= bus_wdata;
    end
  end

  task automatic check(input string t, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", t, what, act, exp);
    end
  endtask

  always @(negedge clk) if (live) begin
    check(tag, "cap_tick", cap_tick, m_cap);
    check(tag, "itv_tick", itv_tick, m_itv);
    check(tag == "R4" ? "R8" : tag, "long_tick", long_tick, m_long);
    n_cap += cap_tick; n_itv += itv_tick; n_long += long_tick;
  end

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk); bus_wr = 1; bus_addr = AW'(CA); bus_wdata = v;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic run(input int cycles, input int d_o, input int d_e, input int d_l, input int wr_rate);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      tick_osc = ($urandom % 100) < d_o;
      tick_ext = ($urandom % 100) < d_e;
      tick_lp  = ($urandom % 100) < d_l;
      bus_wr = (wr_rate > 0) && (($urandom % wr_rate) == 0);
      bus_wdata = ($urandom % 3 == 0) ? m_cfg : 8'($urandom);
    end
    @(negedge clk); bus_wr = 0; tick_osc = 0; tick_ext = 0; tick_lp = 0;
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "rdata", bus_rdata, 8'h8F);
    check("R1", "cap_tick", cap_tick, 0);
    check("R1", "itv_tick", itv_tick, 0);
    check("R1", "long_tick", long_tick, 0);
    live = 1;

    tag = "R2";
    for (int k = 0; k < 8; k++) begin
      logic [7:0] v = 8'($urandom);
      wr_cfg(v);
      check("R2", "readback", bus_rdata, v);
      bus_addr = AW'(CA + 1 + k % 3); #0.5;
      check("R2", "other addr", bus_rdata, 0);
      bus_addr = AW'(CA);
    end

    tag = "R4"; wr_cfg(8'h0F); n_long = 0;
    run(8400, 100, 0, 0, 0);
    check("R8", "long strobes seen", n_long, 1);

    tag = "R6"; wr_cfg(8'h30); n_itv = 0;
    run(300, 40, 0, 0, 0);
    check("R6", "ratio1 gets pulses", int'(n_itv > 0), 1);

    tag = "R9"; wr_cfg(8'h33); n_cap = 0; n_itv = 0; n_long = 0;
    run(400, 90, 90, 90, 0);
    check("R3", "no cap when off", n_cap, 0);
    check("R9", "no cascade when off", n_itv, 0);
    check("R9", "no long when off", n_long, 0);

    tag = "R5"; wr_cfg(8'h47); n_itv = 0;
    run(1000, 20, 70, 10, 0);
    check("R5", "cascade pulses", int'(n_itv > 0), 1);

    tag = "R3"; wr_cfg(8'hE9);
    run(1000, 10, 10, 80, 0);

    tag = "R7";
    for (int s = 0; s < 30; s++) run(500, 60, 50, 40, 25);

    live = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule